// File: doc/BRIEF.md
# Zero-Triggered Phase Resynchronizer

This block sits in the digital front end of an audio converter. It keeps a free-running oversampling phase counter, 256 counts per sample period, in step with an external frame clock. Several converters driven by one frame clock then show the same group delay. Each channel feeds a zero-run detector. The counter is realigned only when the signal is silent on both channels, or while the soft-reset control is held low. Realignment also needs the counter to actually be out of phase at the reference edge.

Both channels first pass through a gain stage before they are detected and output. A silent stream therefore also counts when it comes from full attenuation. When the counter is reloaded, both data outputs are blanked for a short window, measured in sample strobes. The reference edge is taken from the frame clock, or from a separate word clock in external-filter mode. The polarity of that edge depends on the audio format.

Top module: `zr_phase_resync`

## Requirements
- R1: `phase` is 0 while `rstN` is low and otherwise advances by one on every clock, wrapping modulo 2^PHASE_W (256 by default).
- R2: A channel's zero flag rises in the clock after its ZERO_RUN-th consecutive strobe with a zero attenuated value (8192 by default). The run count saturates, so the flag stays high through longer runs.
- R3: A strobe carrying a nonzero attenuated value on a channel clears that channel's flag on the same clock edge, and leaves the other channel's flag alone.
- R4: The attenuated value is floor(sample × attGain / 256), with attGain unsigned in 0..255. On each strobe it is registered to the channel output. It is also the value the zero detector examines.
- R5: A realignment can only happen when `syncEn` is 1 and either `softRstN` is 0 or both zero flags are 1.
- R6: The reference edge is selected as follows. With `extMode`=1 it is a rising edge of `wordClk`, and `frameClk` is ignored. With `extMode`=0 and `i2sFmt`=0 it is a rising edge of `frameClk`. With `extMode`=0 and `i2sFmt`=1 it is a falling edge of `frameClk`. The edge passes through a two-flop synchronizer. The phase is judged in the cycle after the second clock edge that follows the input change.
- R7: If the phase judged at a reference edge is 0, nothing is reloaded. If it is nonzero and R5 allows it, `phase` becomes 1 on the next clock. With a 256-clock frame, the following reference edge then finds 0.
- R8: After a reload both data outputs read 0. They stay 0 until the third sample strobe after the reload, which brings that strobe's sample out.
- R9: With `syncEn`=0, no reference edge ever reloads the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | One-cycle strobe marking a new sample pair |
| leftIn | input | DATA_W | Left sample, two's complement |
| rightIn | input | DATA_W | Right sample, two's complement |
| attGain | input | ATT_W | Gain applied to both channels, in units of 1/256 |
| frameClk | input | 1 | External frame clock |
| wordClk | input | 1 | External word clock for external-filter mode |
| extMode | input | 1 | 1 selects the word clock as reference |
| i2sFmt | input | 1 | 1 selects the falling frame-clock edge |
| syncEn | input | 1 | Enables realignment |
| softRstN | input | 1 | Low allows realignment without silence |
| zeroFlagL | output | 1 | Left zero-run flag |
| zeroFlagR | output | 1 | Right zero-run flag |
| phase | output | PHASE_W | Internal oversampling phase |
| leftOut | output | DATA_W | Gated attenuated left data |
| rightOut | output | DATA_W | Gated attenuated right data |

## Verification
The bench feeds exactly one strobe short of the zero run and then one more. A detector that counts off by one shows the flag at the wrong strobe. The bench sends misaligned edges with only one flag set, with sync disabled, and on the edge polarity or clock that the mode ignores. A design that decodes enables or edges loosely would reload the counter in those cases, and the bench sees a phase of 1 where it expects a steadily advancing value. An edge at phase 0 is sent with live data on the outputs, to catch a reload or blanking that should not happen. After a true reload, the outputs are checked on each of the three following strobes, which catches a blanking window that is one strobe too short or too long.

// File: rtl/zr_pkg.sv
package zr_pkg;
  typedef struct packed {
    logic phaseLoad;
    logic blank;
  } zr_ctl_t;
endpackage

// File: rtl/zr_datapath.sv
module zr_datapath
  import zr_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int ATT_W    = 8,
  parameter int PHASE_W  = 8,
  parameter int ZERO_RUN = 8192
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] leftIn,
  input  logic signed [DATA_W-1:0] rightIn,
  input  logic [ATT_W-1:0]         attGain,
  input  zr_ctl_t                  ctl,
  output logic                     zeroFlagL,
  output logic                     zeroFlagR,
  output logic [PHASE_W-1:0]       phase,
  output logic signed [DATA_W-1:0] leftOut,
  output logic signed [DATA_W-1:0] rightOut
);
  localparam int PROD_W = DATA_W + ATT_W + 1;
  localparam int RUN_W  = $clog2(ZERO_RUN + 1);
  localparam int NCH    = 2;

  logic signed [DATA_W-1:0] chanIn  [NCH];
  logic signed [DATA_W-1:0] chanOut [NCH];
  logic                     chanZero[NCH];

  assign chanIn[0] = leftIn;
  assign chanIn[1] = rightIn;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic signed [PROD_W-1:0] prod;
    logic signed [DATA_W-1:0] scaled;
    logic signed [DATA_W-1:0] held;
    logic [RUN_W-1:0]         runCount;

    assign prod   = PROD_W'(chanIn[ch]) * PROD_W'($signed({1'b0, attGain}));
    assign scaled = prod[ATT_W +: DATA_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        held     <= '0;
        runCount <= '0;
      end else if (sampleValid) begin
        held <= scaled;
        if (scaled != '0)
          runCount <= '0;
        else if (runCount != RUN_W'(ZERO_RUN))
          runCount <= runCount + RUN_W'(1);
      end
    end

    assign chanZero[ch] = (runCount == RUN_W'(ZERO_RUN));
    assign chanOut[ch]  = ctl.blank ? '0 : held;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      phase <= '0;
    else if (ctl.phaseLoad)
      phase <= PHASE_W'(1);
    else
      phase <= phase + PHASE_W'(1);
  end

  assign zeroFlagL = chanZero[0];
  assign zeroFlagR = chanZero[1];
  assign leftOut   = chanOut[0];
  assign rightOut  = chanOut[1];
endmodule

// File: rtl/zr_control.sv
module zr_control
  import zr_pkg::*;
#(
  parameter int PHASE_W       = 8,
  parameter int BLANK_STROBES = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic               frameClk,
  input  logic               wordClk,
  input  logic               extMode,
  input  logic               i2sFmt,
  input  logic               syncEn,
  input  logic               softRstN,
  input  logic               zeroFlagL,
  input  logic               zeroFlagR,
  input  logic [PHASE_W-1:0] phase,
  output zr_ctl_t            ctl
);
  localparam int BLANK_W = $clog2(BLANK_STROBES + 1);

  logic               refIn;
  logic               wantFall;
  logic [2:0]         refSync;
  logic               refRise, refFall, refEdge;
  logic               allowed;
  logic               phaseLoad;
  logic               blank;
  logic [BLANK_W-1:0] strobeCount;

  assign refIn    = extMode ? wordClk : frameClk;
  assign wantFall = !extMode && i2sFmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refSync <= '0;
    else       refSync <= {refSync[1:0], refIn};
  end

  assign refRise = refSync[1] && !refSync[2];
  assign refFall = !refSync[1] && refSync[2];
  assign refEdge = wantFall ? refFall : refRise;

  assign allowed   = syncEn && (!softRstN || (zeroFlagL && zeroFlagR));
  assign phaseLoad = refEdge && allowed && (phase != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blank       <= 1'b0;
      strobeCount <= '0;
    end else if (phaseLoad) begin
      blank       <= 1'b1;
      strobeCount <= '0;
    end else if (blank && sampleValid) begin
      if (strobeCount == BLANK_W'(BLANK_STROBES - 1))
        blank <= 1'b0;
      else
        strobeCount <= strobeCount + BLANK_W'(1);
    end
  end

  assign ctl.phaseLoad = phaseLoad;
  assign ctl.blank     = blank;
endmodule

// File: rtl/zr_phase_resync.sv
module zr_phase_resync
  import zr_pkg::*;
#(
  parameter int DATA_W        = 24,
  parameter int ATT_W         = 8,
  parameter int PHASE_W       = 8,
  parameter int ZERO_RUN      = 8192,
  parameter int BLANK_STROBES = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] leftIn,
  input  logic signed [DATA_W-1:0] rightIn,
  input  logic [ATT_W-1:0]         attGain,
  input  logic                     frameClk,
  input  logic                     wordClk,
  input  logic                     extMode,
  input  logic                     i2sFmt,
  input  logic                     syncEn,
  input  logic                     softRstN,
  output logic                     zeroFlagL,
  output logic                     zeroFlagR,
  output logic [PHASE_W-1:0]       phase,
  output logic signed [DATA_W-1:0] leftOut,
  output logic signed [DATA_W-1:0] rightOut
);
  zr_ctl_t ctlBus;

  zr_control #(
    .PHASE_W(PHASE_W),
    .BLANK_STROBES(BLANK_STROBES)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .frameClk(frameClk), .wordClk(wordClk), .extMode(extMode), .i2sFmt(i2sFmt),
    .syncEn(syncEn), .softRstN(softRstN),
    .zeroFlagL(zeroFlagL), .zeroFlagR(zeroFlagR), .phase(phase),
    .ctl(ctlBus)
  );

  zr_datapath #(
    .DATA_W(DATA_W), .ATT_W(ATT_W), .PHASE_W(PHASE_W), .ZERO_RUN(ZERO_RUN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .leftIn(leftIn), .rightIn(rightIn), .attGain(attGain),
    .ctl(ctlBus),
    .zeroFlagL(zeroFlagL), .zeroFlagR(zeroFlagR), .phase(phase),
    .leftOut(leftOut), .rightOut(rightOut)
  );
endmodule

// File: rtl/zr_checker.sv
module zr_checker #(
  parameter int DATA_W  = 24,
  parameter int ATT_W   = 8,
  parameter int PHASE_W = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     sampleValid,
  input logic signed [DATA_W-1:0] leftIn,
  input logic [ATT_W-1:0]         attGain,
  input logic                     syncEn,
  input logic                     softRstN,
  input logic                     zeroFlagL,
  input logic                     zeroFlagR,
  input logic [PHASE_W-1:0]       phase,
  input logic signed [DATA_W-1:0] leftOut,
  input logic signed [DATA_W-1:0] rightOut,
  input logic                     phaseLoad
);
  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (phase == PHASE_W'($past(phase) + PHASE_W'(1))) || (phase == PHASE_W'(1)));

  p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && (leftIn > 1) && (attGain == '1)) |=> !zeroFlagL);

  p_load_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    phaseLoad |-> (!softRstN || (zeroFlagL && zeroFlagR)));

  p_aligned_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    phaseLoad |-> (phase != '0));

  p_load_blanks_r8: assert property (@(posedge clk) disable iff (!rstN)
    phaseLoad |=> (leftOut == '0 && rightOut == '0));

  p_disabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    !syncEn |=> (phase == PHASE_W'($past(phase) + PHASE_W'(1))));
endmodule

bind zr_phase_resync zr_checker #(
  .DATA_W(DATA_W), .ATT_W(ATT_W), .PHASE_W(PHASE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .leftIn(leftIn),
  .attGain(attGain), .syncEn(syncEn), .softRstN(softRstN),
  .zeroFlagL(zeroFlagL), .zeroFlagR(zeroFlagR), .phase(phase),
  .leftOut(leftOut), .rightOut(rightOut), .phaseLoad(ctlBus.phaseLoad)
);

// File: tb/zr_phase_resync_tb.sv
module zr_phase_resync_tb;
  localparam int DW  = 24;
  localparam int RUN = 8192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [DW-1:0] leftIn = '0, rightIn = '0;
  logic [7:0] attGain = 8'd255;
  logic frameClk = 1'b0, wordClk = 1'b0, extMode = 1'b0, i2sFmt = 1'b0;
  logic syncEn = 1'b1, softRstN = 1'b1;
  logic zeroFlagL, zeroFlagR;
  logic [7:0] phase;
  logic signed [DW-1:0] leftOut, rightOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  zr_phase_resync u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .leftIn(leftIn), .rightIn(rightIn), .attGain(attGain),
    .frameClk(frameClk), .wordClk(wordClk), .extMode(extMode), .i2sFmt(i2sFmt),
    .syncEn(syncEn), .softRstN(softRstN),
    .zeroFlagL(zeroFlagL), .zeroFlagR(zeroFlagR), .phase(phase),
    .leftOut(leftOut), .rightOut(rightOut)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint atten(input longint s, input longint g);
    longint p;
    p = s * g;
    return (p >= 0) ? p / 256 : -((-p + 255) / 256);
  endfunction

  task automatic pushSample(input longint l, input longint r);
    @(negedge clk);
    sampleValid = 1'b1;
    leftIn  = DW'(l);
    rightIn = DW'(r);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // which: 0 frameClk, 1 wordClk. Returns phase three clocks after the change.
  task automatic edgeAt(input int which, input logic lvl, input logic [7:0] t,
                        input bit expectLoad, input string req);
    @(negedge clk);
    while (phase != t) @(negedge clk);
    if (which == 0) frameClk = lvl; else wordClk = lvl;
    repeat (3) @(negedge clk);
    check(req, phase, expectLoad ? 1 : 8'(t + 8'd3));
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 reset phase", phase, 0);
    check("R2 reset flagL", zeroFlagL, 0);
    check("R2 reset flagR", zeroFlagR, 0);
    check("R8 reset out", leftOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 first step", phase, 1);
    while (phase != 8'd250) @(negedge clk);
    repeat (10) @(negedge clk);
    check("R1 wrap", phase, 4);
  endtask

  task automatic testAtten();
    attGain = 8'd128;
    pushSample(1000, -1000);
    check("R4 gain128 L", leftOut, atten(1000, 128));
    check("R4 gain128 R", rightOut, atten(-1000, 128));
    attGain = 8'd255;
    pushSample(2560, -2560);
    check("R4 gain255 L", leftOut, 2550);
    check("R4 gain255 R", rightOut, -2550);
  endtask

  task automatic testDisabled();
    softRstN = 1'b0; syncEn = 1'b0;
    edgeAt(0, 1'b1, 8'd100, 0, "R9 sync disabled");
    frameClk = 1'b0;
    repeat (4) @(negedge clk);
    syncEn = 1'b1;
  endtask

  task automatic testSoftReset();
    pushSample(2560, -2560);
    edgeAt(0, 1'b1, 8'd254, 0, "R7 aligned edge");
    check("R7 aligned keeps L", leftOut, 2550);
    frameClk = 1'b0;
    repeat (4) @(negedge clk);
    edgeAt(0, 1'b1, 8'd100, 1, "R7 misaligned reload");
    check("R8 blank L", leftOut, 0);
    check("R8 blank R", rightOut, 0);
    pushSample(5120, 5120);
    check("R8 strobe1", leftOut, 0);
    pushSample(5120, 5120);
    check("R8 strobe2", leftOut, 0);
    pushSample(5120, -5120);
    check("R8 strobe3 L", leftOut, 5100);
    check("R8 strobe3 R", rightOut, -5100);
    frameClk = 1'b0;
    repeat (4) @(negedge clk);
    softRstN = 1'b1;
  endtask

  task automatic testZeroTrigger();
    edgeAt(0, 1'b1, 8'd100, 0, "R5 no silence");
    frameClk = 1'b0;
    for (int i = 0; i < RUN - 1; i++) pushSample(0, 0);
    check("R2 one short L", zeroFlagL, 0);
    check("R2 one short R", zeroFlagR, 0);
    pushSample(0, 0);
    check("R2 run met L", zeroFlagL, 1);
    check("R2 run met R", zeroFlagR, 1);
    for (int i = 0; i < 5; i++) pushSample(0, 0);
    check("R2 saturated", zeroFlagL, 1);
    edgeAt(0, 1'b1, 8'd100, 1, "R5 silence reload");
    frameClk = 1'b0;
    repeat (4) @(negedge clk);
    pushSample(2560, 0);
    check("R3 flagL cleared", zeroFlagL, 0);
    check("R3 flagR kept", zeroFlagR, 1);
    edgeAt(0, 1'b1, 8'd100, 0, "R5 one flag only");
    frameClk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testAttenZero();
    attGain = 8'd0;
    for (int i = 0; i < RUN; i++) pushSample(4000, -4000);
    check("R4 attenuated zero L", zeroFlagL, 1);
    check("R4 attenuated zero R", zeroFlagR, 1);
    check("R4 attenuated out", leftOut, 0);
    attGain = 8'd255;
    pushSample(4000, 4000);
    check("R3 gain restored", zeroFlagR, 0);
  endtask

  task automatic testFallEdge();
    softRstN = 1'b0; i2sFmt = 1'b1;
    repeat (4) @(negedge clk);
    edgeAt(0, 1'b1, 8'd100, 0, "R6 i2s rise ignored");
    edgeAt(0, 1'b0, 8'd100, 1, "R6 i2s fall reload");
    i2sFmt = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testWordClk();
    extMode = 1'b1;
    repeat (4) @(negedge clk);
    edgeAt(0, 1'b1, 8'd100, 0, "R6 frame ignored ext");
    edgeAt(1, 1'b1, 8'd100, 1, "R6 word rise reload");
    frameClk = 1'b0; wordClk = 1'b0;
    repeat (4) @(negedge clk);
    extMode = 1'b0; softRstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    testReset();
    testAtten();
    testDisabled();
    testSoftReset();
    testZeroTrigger();
    testAttenZero();
    testFallEdge();
    testWordClk();
    done = 1;
    finishRun();
  end
endmodule